// File: doc/BRIEF.md
# Serial LED Sink Load Controller

This block feeds a 16-channel constant-current LED sink that takes its settings over a bit-serial link. The link has a data line, a serial clock, a latch strobe, a blanking line and two mode lines. One mode line selects programming mode. The other selects where the sink takes its correction values from. All link timing comes from the system clock through a programmable divider. Every serial clock level and every latch level lasts one divider period.

When reset ends, the block sets itself up once without any request. It first puts the sink in correction mode and shifts a full-scale correction pattern, then latches it. It then leaves correction mode, clears the grayscale register by shifting zeros, and latches again. It ends setup with one extra clock pulse, which the sink needs after leaving correction mode. After that the block sits idle. A request makes it send sixteen 12-bit grayscale words, which come from a small register array that an external writer fills, and latch them. The outputs are blanked for the whole transfer and come back on when the latch ends. `busy` covers both setup and transfers, and `done` pulses once when each transfer finishes.

Top module: `led_sink_loader`

## Requirements
- R1: While reset is low and on the first cycle after it: `blankOut`=1, `progMode`=1, `corrSel`=1, `serClk`=0, `latchStb`=0, `busy`=1.
- R2: Setup first makes 96 rising edges of `serClk` with `serData`=1 and `progMode`=1, followed by one `latchStb` pulse.
- R3: After that latch, `progMode` is 0 and setup makes 192 rising edges with `serData`=0, followed by a second `latchStb` pulse. `progMode` changes only while `serClk` and `latchStb` are both low.
- R4: Setup ends with exactly one more `serClk` pulse after the second latch, for 289 pulses in total. `busy` stays 1 until that pulse is over.
- R5: A `loadReq` pulse while idle raises `blankOut` and `busy`. The block then makes 192 `serClk` rising edges and one `latchStb` pulse. The words go out in address order 0 to 15, and each word goes out bit 0 first and bit 11 last. `blankOut` is 1 when the latch rises.
- R6: `serData` holds its value through the cycle in which `serClk` rises and for as long as `serClk` stays high. `serClk` and `latchStb` are never high at the same time.
- R7: Each high level and each low level of `serClk` inside a transfer lasts `divRatio`+1 system clocks. The same holds for `latchStb`.
- R8: On the edge where the transfer latch falls, `blankOut` goes to 0, `busy` goes to 0 and `done` is 1 for exactly one cycle.
- R9: A `loadReq` that arrives while `busy`=1, during setup or during a transfer, produces no extra bits, latches or `done` pulses.
- R10: A cycle with `wrEn`=1 stores `wrData` at word `wrAddr` (0 to 15), and the next transfer sends that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divRatio | input | 8 | Each link level lasts divRatio+1 clocks |
| loadReq | input | 1 | Start a grayscale transfer (taken only when idle) |
| wrEn | input | 1 | Write enable for the word array |
| wrAddr | input | 4 | Word address for writes |
| wrData | input | 12 | Grayscale word to store |
| serData | output | 1 | Serial data to the sink |
| serClk | output | 1 | Serial clock to the sink |
| latchStb | output | 1 | Latch strobe to the sink |
| blankOut | output | 1 | Blanking, 1 = sink outputs off |
| progMode | output | 1 | 1 = correction programming mode, 0 = grayscale mode |
| corrSel | output | 1 | Correction source select, held at 1 |
| busy | output | 1 | Setup or transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer has latched |

## Verification
The bench uses the default widths: 16 channels, 12-bit words, 6-bit correction fields and an 8-bit divider. With these, the whole 289-pulse setup and several full transfers fit in a short run. The divider is set to 3 for setup and the first transfers, so every link level lasts four clocks and the timing is easy to measure. It is then set to 0 for the last transfer, which checks the shortest level of one clock. A second request sent in the middle of a transfer, and another sent during setup, exercise the rule that requests are ignored while busy.

// File: rtl/sld_pkg.sv
package sld_pkg;

  // Selects what the serial data line carries.
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ONES = 2'd1,
    SRC_MEM  = 2'd2
  } srcSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    cntClr;   // restart the word/bit counters
    logic    cntAdv;   // move to the next bit
    logic    dcWidth;  // words are correction width, not grayscale width
    logic    divClr;   // restart the divider
    srcSel_e src;      // data source
  } dpCtrl_t;

endpackage

// File: rtl/sld_datapath.sv
module sld_datapath
  import sld_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int GS_BITS = 12,
  parameter int DC_BITS = 6,
  parameter int DIV_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtrl_t                   ctrl,
  input  logic [DIV_W-1:0]          divRatio,
  input  logic                      wrEn,
  input  logic [$clog2(NUM_CH)-1:0] wrAddr,
  input  logic [GS_BITS-1:0]        wrData,
  output logic                      tick,
  output logic                      lastBit,
  output logic                      serData
);

  localparam int AW = $clog2(NUM_CH);
  localparam int BW = $clog2(GS_BITS);
  localparam logic [BW-1:0] GS_TOP   = BW'(GS_BITS - 1);
  localparam logic [BW-1:0] DC_TOP   = BW'(DC_BITS - 1);
  localparam logic [AW-1:0] WORD_TOP = AW'(NUM_CH - 1);

  // Grayscale word array, one register per channel
  logic [GS_BITS-1:0] gsMem [NUM_CH];

  for (genvar w = 0; w < NUM_CH; w++) begin : g_word
    logic hit;
    assign hit = wrEn && (wrAddr == AW'(w));
    always_ff @(posedge clk) begin
      if (!rstN)    gsMem[w] <= '0;
      else if (hit) gsMem[w] <= wrData;
    end
  end

  // Phase divider: one tick per link level
  logic [DIV_W-1:0] divCnt;
  assign tick = (divCnt >= divRatio);

  always_ff @(posedge clk) begin
    if (!rstN)                  divCnt <= '0;
    else if (ctrl.divClr || tick) divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;
  end

  // Word and bit position
  logic [AW-1:0] wordIdx;
  logic [BW-1:0] bitIdx;
  logic [BW-1:0] wordTop;

  assign wordTop = ctrl.dcWidth ? DC_TOP : GS_TOP;
  assign lastBit = (wordIdx == WORD_TOP) && (bitIdx == wordTop);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.cntClr) begin
      wordIdx <= '0;
      bitIdx  <= '0;
    end else if (ctrl.cntAdv) begin
      if (bitIdx == wordTop) begin
        bitIdx  <= '0;
        wordIdx <= wordIdx + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // Data source mux; word bit 0 leaves first
  logic [GS_BITS-1:0] curWord;
  assign curWord = gsMem[wordIdx];

  always_comb begin
    unique case (ctrl.src)
      SRC_ONES: serData = 1'b1;
      SRC_MEM:  serData = curWord[bitIdx];
      default:  serData = 1'b0;
    endcase
  end

  // R5
  word_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordIdx <= WORD_TOP) && (bitIdx <= GS_TOP));

  // R5
  adv_not_past_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cntAdv |-> !lastBit);

endmodule

// File: rtl/sld_control.sv
module sld_control
  import sld_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    lastBit,
  input  logic    loadReq,
  output dpCtrl_t ctrl,
  output logic    serClk,
  output logic    latchStb,
  output logic    blankOut,
  output logic    progMode,
  output logic    corrSel,
  output logic    busy,
  output logic    done
);

  typedef enum logic [2:0] {
    ST_DC_SHIFT = 3'd0,
    ST_DC_LATCH = 3'd1,
    ST_FL_SHIFT = 3'd2,
    ST_FL_LATCH = 3'd3,
    ST_EXTRA    = 3'd4,
    ST_IDLE     = 3'd5,
    ST_LD_SHIFT = 3'd6,
    ST_LD_LATCH = 3'd7
  } state_e;

  state_e state;
  logic   half;      // 0 = first level of a pulse, 1 = second level
  logic   shifting;
  logic   accept;

  assign shifting = (state == ST_DC_SHIFT) || (state == ST_FL_SHIFT) ||
                    (state == ST_LD_SHIFT);
  assign accept   = (state == ST_IDLE) && loadReq;
  assign busy     = (state != ST_IDLE);
  assign corrSel  = 1'b1;

  always_comb begin
    ctrl.dcWidth = (state == ST_DC_SHIFT);
    ctrl.cntAdv  = shifting && tick && half && !lastBit;
    ctrl.cntClr  = ((state == ST_DC_LATCH) && tick && half) || accept;
    ctrl.divClr  = accept;
    if (state == ST_DC_SHIFT)      ctrl.src = SRC_ONES;
    else if (state == ST_LD_SHIFT) ctrl.src = SRC_MEM;
    else                           ctrl.src = SRC_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_DC_SHIFT;
      half     <= 1'b0;
      serClk   <= 1'b0;
      latchStb <= 1'b0;
      blankOut <= 1'b1;
      progMode <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_DC_SHIFT, ST_FL_SHIFT, ST_LD_SHIFT: begin
          if (tick) begin
            if (!half) begin
              serClk <= 1'b1;
              half   <= 1'b1;
            end else begin
              serClk <= 1'b0;
              half   <= 1'b0;
              if (lastBit) begin
                if (state == ST_DC_SHIFT)      state <= ST_DC_LATCH;
                else if (state == ST_FL_SHIFT) state <= ST_FL_LATCH;
                else                           state <= ST_LD_LATCH;
              end
            end
          end
        end
        ST_DC_LATCH, ST_FL_LATCH, ST_LD_LATCH: begin
          if (tick) begin
            if (!half) begin
              latchStb <= 1'b1;
              half     <= 1'b1;
            end else begin
              latchStb <= 1'b0;
              half     <= 1'b0;
              if (state == ST_DC_LATCH) begin
                state    <= ST_FL_SHIFT;
                progMode <= 1'b0;
              end else if (state == ST_FL_LATCH) begin
                state <= ST_EXTRA;
              end else begin
                state    <= ST_IDLE;
                blankOut <= 1'b0;
                done     <= 1'b1;
              end
            end
          end
        end
        ST_EXTRA: begin
          if (tick) begin
            if (!half) begin
              serClk <= 1'b1;
              half   <= 1'b1;
            end else begin
              serClk <= 1'b0;
              half   <= 1'b0;
              state  <= ST_IDLE;
            end
          end
        end
        default: begin // ST_IDLE
          half <= 1'b0;
          if (loadReq) begin
            state    <= ST_LD_SHIFT;
            blankOut <= 1'b1;
          end
        end
      endcase
    end
  end

  // R6
  clk_latch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(serClk && latchStb));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_unblank_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!blankOut && !busy));

  // R9
  blank_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blankOut) |-> $past(!busy && loadReq));

  // R3
  prog_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progMode) |-> (!serClk && !latchStb));

endmodule

// File: rtl/led_sink_loader.sv
module led_sink_loader
  import sld_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int GS_BITS = 12,
  parameter int DC_BITS = 6,
  parameter int DIV_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DIV_W-1:0]          divRatio,
  input  logic                      loadReq,
  input  logic                      wrEn,
  input  logic [$clog2(NUM_CH)-1:0] wrAddr,
  input  logic [GS_BITS-1:0]        wrData,
  output logic                      serData,
  output logic                      serClk,
  output logic                      latchStb,
  output logic                      blankOut,
  output logic                      progMode,
  output logic                      corrSel,
  output logic                      busy,
  output logic                      done
);

  dpCtrl_t ctrl;
  logic    tick;
  logic    lastBit;

  sld_datapath #(
    .NUM_CH (NUM_CH),
    .GS_BITS(GS_BITS),
    .DC_BITS(DC_BITS),
    .DIV_W  (DIV_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .divRatio(divRatio),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .tick    (tick),
    .lastBit (lastBit),
    .serData (serData)
  );

  sld_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .lastBit (lastBit),
    .loadReq (loadReq),
    .ctrl    (ctrl),
    .serClk  (serClk),
    .latchStb(latchStb),
    .blankOut(blankOut),
    .progMode(progMode),
    .corrSel (corrSel),
    .busy    (busy),
    .done    (done)
  );

  // R6
  data_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> $stable(serData));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData));

endmodule

// File: tb/led_sink_loader_tb.sv
`timescale 1ns/1ps
module led_sink_loader_tb;

  localparam int NUM_CH  = 16;
  localparam int GS_BITS = 12;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  divRatio;
  logic        loadReq, wrEn;
  logic [3:0]  wrAddr;
  logic [11:0] wrData;
  logic serData, serClk, latchStb, blankOut, progMode, corrSel, busy, done;

  always #2 clk = ~clk;

  led_sink_loader u_dut (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .loadReq(loadReq),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .serData(serData),
    .serClk(serClk), .latchStb(latchStb), .blankOut(blankOut),
    .progMode(progMode), .corrSel(corrSel), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Link monitor, sampled on the falling clock edge
  logic bitLog  [0:2047];
  logic modeLog [0:2047];
  int   bitCnt = 0, latCnt = 0, doneCnt = 0;
  int   latAt [0:15];
  logic blankAtLat [0:15];
  int   hiRun = 0, loRun = 0, minHi = 9999, maxHi = 0, minLo = 9999;
  int   latRun = 0, minLat = 9999, maxLat = 0;
  int   setupBad = 0, overlap = 0, doneRun = 0, maxDoneRun = 0;
  logic prevClk = 1'b0, prevLat = 1'b0, prevData = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (serClk && !prevClk) begin
        if (serData !== prevData) setupBad++;
        if (loRun < minLo) minLo = loRun;
        loRun = 0; hiRun = 1;
        if (bitCnt < 2048) begin
          bitLog[bitCnt]  = serData;
          modeLog[bitCnt] = progMode;
        end
        bitCnt++;
      end else if (!serClk && prevClk) begin
        if (hiRun < minHi) minHi = hiRun;
        if (hiRun > maxHi) maxHi = hiRun;
        hiRun = 0; loRun = 1;
      end else if (serClk) hiRun++;
      else loRun++;
      if (latchStb && !prevLat) begin
        if (latCnt < 16) begin
          latAt[latCnt]      = bitCnt;
          blankAtLat[latCnt] = blankOut;
        end
        latCnt++;
        latRun = 1;
      end else if (latchStb) latRun++;
      else if (prevLat) begin
        if (latRun < minLat) minLat = latRun;
        if (latRun > maxLat) maxLat = latRun;
      end
      if (serClk && latchStb) overlap++;
      if (done) begin
        doneCnt++; doneRun++;
        if (doneRun > maxDoneRun) maxDoneRun = doneRun;
      end else doneRun = 0;
      prevClk = serClk; prevLat = latchStb; prevData = serData;
    end
  end

  logic [11:0] pattern [0:15];

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, req, "busy did not fall", busy, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0; loadReq = 0; wrEn = 0; wrAddr = 0; wrData = 0; divRatio = 8'd3;
    repeat (3) @(negedge clk);
    check(blankOut && progMode && corrSel && !serClk && !latchStb && busy,
          "R1", "outputs in reset",
          {blankOut, progMode, corrSel, serClk, latchStb, busy}, 6'b111001);
    rstN = 1'b1;
    @(negedge clk);
    check(blankOut && progMode && corrSel && !serClk && !latchStb && busy,
          "R1", "outputs after reset",
          {blankOut, progMode, corrSel, serClk, latchStb, busy}, 6'b111001);
  endtask

  task automatic testInit();
    int ones = 0, zeros = 0;
    repeat (10) @(negedge clk);
    loadReq = 1; @(negedge clk); loadReq = 0;   // R9: ignored during setup
    waitIdle("R4");
    repeat (3) @(negedge clk);
    for (int i = 0; i < 96; i++) if (bitLog[i] && modeLog[i]) ones++;
    for (int i = 96; i < 288; i++) if (!bitLog[i] && !modeLog[i]) zeros++;
    check(ones == 96, "R2", "correction ones with progMode=1", ones, 96);
    check(latAt[0] == 96, "R2", "first latch position", latAt[0], 96);
    check(zeros == 192, "R3", "flush zeros with progMode=0", zeros, 192);
    check(latAt[1] == 288, "R3", "second latch position", latAt[1], 288);
    check(bitCnt == 289, "R4", "setup clock pulses", bitCnt, 289);
    check(latCnt == 2, "R9", "latches during setup", latCnt, 2);
    check(doneCnt == 0, "R9", "done during setup", doneCnt, 0);
    check(blankOut == 1'b1, "R4", "blank after setup", blankOut, 1);
  endtask

  task automatic writeWords(input int kind);
    for (int w = 0; w < NUM_CH; w++) begin
      case (kind)
        0:       pattern[w] = 12'((w * 12'h111) ^ 12'hA5C);
        1:       pattern[w] = (w % 2 == 0) ? 12'hFFF : 12'h000;
        default: pattern[w] = 12'(1 << (w % GS_BITS));
      endcase
      wrEn = 1; wrAddr = 4'(w); wrData = pattern[w];
      @(negedge clk);
    end
    wrEn = 0;
  endtask

  task automatic doLoad(input int div, input bit extraReq, input string tag);
    int base = bitCnt, latBase = latCnt, doneBase = doneCnt, bad = 0;
    divRatio = 8'(div);
    minHi = 9999; maxHi = 0; minLo = 9999; minLat = 9999; maxLat = 0;
    setupBad = 0; overlap = 0; maxDoneRun = 0;
    loadReq = 1; @(negedge clk); loadReq = 0;
    check(blankOut && busy, "R5", {tag, " blank/busy at start"},
          {blankOut, busy}, 2'b11);
    if (extraReq) begin
      repeat (50) @(negedge clk);
      loadReq = 1; @(negedge clk); loadReq = 0;
    end
    waitIdle("R8");
    repeat (3) @(negedge clk);
    check(bitCnt - base == 192, "R9", {tag, " bits per transfer"}, bitCnt - base, 192);
    for (int k = 0; k < 192; k++)
      if (bitLog[base + k] !== pattern[k / GS_BITS][k % GS_BITS]) bad++;
    check(bad == 0, "R5", {tag, " bit order mismatches"}, bad, 0);
    check(latCnt - latBase == 1, "R9", {tag, " latches"}, latCnt - latBase, 1);
    check(latAt[latBase] == base + 192, "R5", {tag, " latch after last bit"},
          latAt[latBase], base + 192);
    check(blankAtLat[latBase] == 1'b1, "R5", {tag, " blank during latch"},
          blankAtLat[latBase], 1);
    check(blankOut == 1'b0, "R8", {tag, " blank released"}, blankOut, 0);
    check(doneCnt - doneBase == 1, "R8", {tag, " done pulses"}, doneCnt - doneBase, 1);
    check(maxDoneRun == 1, "R8", {tag, " done width"}, maxDoneRun, 1);
    check(minHi == div + 1 && maxHi == div + 1, "R7", {tag, " clock high width"},
          maxHi, div + 1);
    check(minLo == div + 1, "R7", {tag, " clock low width"}, minLo, div + 1);
    check(minLat == div + 1 && maxLat == div + 1, "R7", {tag, " latch width"},
          maxLat, div + 1);
    check(setupBad == 0, "R6", {tag, " data changed at clock rise"}, setupBad, 0);
    check(overlap == 0, "R6", {tag, " clock and latch overlap"}, overlap, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testInit();
    writeWords(0);               // R10
    doLoad(3, 1'b0, "load A");
    writeWords(1);               // R10
    doLoad(3, 1'b1, "load B");   // R9: second request mid-transfer
    writeWords(2);               // R10
    doLoad(0, 1'b0, "load C");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule